// File: doc/BRIEF.md
# Link Port Packing Receiver

This block is the receive side of a byte-wide or nibble-wide point-to-point link. A remote transmitter presents one unit of data on the link data lines and raises the link strobe. The receiver takes the unit when the strobe falls. It assembles the units into 32-bit or 48-bit words, most significant unit first, and places each finished word in a two-entry FIFO. The receiver drives an acknowledge line that tells the transmitter whether it may begin another word.

The link strobe and data come from outside the core clock domain. Both pass through a two-stage synchronizer. A falling edge is found on the synchronized strobe, and the synchronized data is taken in that same cycle. Software or a DMA engine drains the FIFO through a valid/ready read stream. `rd_valid` is high while at least one word is held. A word leaves the FIFO on each clock edge where `rd_valid` and `rd_ready` are both high. Back-pressure toward the link comes only from the acknowledge line.

A 2-bit status and a packing-error flag report the fill level and any partial word left in the packer. The word-size and path-width selects may only change while `en` is low.

Top module: `lnk_pack_rx`

## Requirements
- R1: A unit is taken only on a falling edge of `lnk_clk`, as seen after a two-stage synchronizer. A rising edge captures nothing. The unit is the synchronized `lnk_dat` of that same cycle.
- R2: Units are packed most significant first. The number of units per word depends on the two selects:
  - `word48`=0, `path8`=1: 4 bytes.
  - `word48`=0, `path8`=0: 8 nibbles.
  - `word48`=1, `path8`=1: 6 bytes.
  - `word48`=1, `path8`=0: 12 nibbles.
  
  In 4-bit mode only `lnk_dat[3:0]` is used. A 32-bit word appears on `rd_data[31:0]` with `rd_data[47:32]`=0.
- R3: The FIFO holds two words and delivers them in arrival order. `rd_valid` is high while one or more words are held. `rd_data` shows the oldest word.
- R4: `lnk_ack` is low when the FIFO is full. It is also low when one word is held and a word is partly received.
- R5: When a read frees an entry and no partial word is pending, `lnk_ack` is high from the clock edge of the read onward.
- R6: After `lnk_ack` falls, the receiver still accepts every remaining unit of the word in progress and stores that word.
- R7: `status` reads 2'b00 when the FIFO is empty, 2'b10 with one word held, and 2'b11 when full. The value 2'b01 never appears.
- R8: `pack_err` is 1 exactly while the packer holds a partial word, and 0 when a whole number of words has been received.
- R9: With `en` low, the following hold:
  - One clock later, the FIFO, packer, `status` and `pack_err` are cleared.
  - `lnk_ack` is 0.
  - Strobe edges are ignored.
- R10: A read with `rd_valid` low changes no state. `rd_data` then shows the last word that was read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Receiver enable; low clears the receiver |
| word48 | input | 1 | Word size: 1 = 48-bit, 0 = 32-bit |
| path8 | input | 1 | Path width: 1 = 8-bit units, 0 = 4-bit units |
| lnk_clk | input | 1 | Asynchronous link strobe from the transmitter |
| lnk_dat | input | 8 | Asynchronous link data |
| lnk_ack | output | 1 | Acknowledge back to the transmitter |
| rd_ready | input | 1 | Read strobe of the output stream |
| rd_valid | output | 1 | At least one word is held |
| rd_data | output | 48 | Oldest word, or the last word read when empty |
| status | output | 2 | Fill status (00 empty, 10 one word, 11 full) |
| pack_err | output | 1 | A partial word is held in the packer |

## Verification
The following wrong internal states show up at the ports:
- A wrong unit counter is visible as soon as the strobe falls. `pack_err` is wrong during any partial word, and the next word read back is shifted or mixed up.
- A FIFO pointer or count fault reaches `status` and `rd_data` on the edge after the push or read that caused it.
- A wrong acknowledge condition shows on `lnk_ack` three core cycles after the strobe falls on the first unit of a second word.

All outputs are checked within a few cycles of each link unit and each read, so a fault cannot stay hidden past the end of the word in which it arises.

// File: rtl/lnk_rx_pkg.sv
package lnk_rx_pkg;
  localparam int unsigned LANE_W  = 8;
  localparam int unsigned NIB_W   = 4;
  localparam int unsigned WORD_W  = 48;
  localparam int unsigned SHORT_W = 32;
  localparam int unsigned MAX_UNITS = WORD_W / NIB_W;
  localparam int unsigned UCNT_W  = $clog2(MAX_UNITS);

  localparam logic [1:0] ST_EMPTY = 2'b00;
  localparam logic [1:0] ST_ONE   = 2'b10;
  localparam logic [1:0] ST_FULL  = 2'b11;

  function automatic logic [UCNT_W-1:0] units_per_word(input logic wide, input logic bytes);
    int unsigned bits;
    bits = wide ? WORD_W : SHORT_W;
    return UCNT_W'(bits / (bytes ? LANE_W : NIB_W));
  endfunction
endpackage

// File: rtl/lnk_sync.sv
module lnk_sync #(
  parameter int unsigned W      = 9,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= '0;
        else if (s == 0) stg[s] <= d;
        else stg[s] <= stg[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/lnk_packer.sv
module lnk_packer
  import lnk_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              word48,
  input  logic              path8,
  input  logic              strobe_s,
  input  logic [LANE_W-1:0] dat_s,
  output logic              push_o,
  output logic [WORD_W-1:0] word_o,
  output logic              busy_o
);
  logic              strobe_prev;
  logic              fall;
  logic [UCNT_W-1:0] unit_cnt;
  logic [UCNT_W-1:0] units;
  logic              last_unit;
  logic [WORD_W-1:0] acc;
  logic [WORD_W-1:0] acc_next;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strobe_prev <= 1'b0;
    else strobe_prev <= strobe_s;
  end

  assign fall      = en & strobe_prev & ~strobe_s;
  assign units     = units_per_word(word48, path8);
  assign last_unit = (unit_cnt == units - UCNT_W'(1));

  always_comb begin
    if (path8) acc_next = {acc[WORD_W-LANE_W-1:0], dat_s};
    else       acc_next = {acc[WORD_W-NIB_W-1:0], dat_s[NIB_W-1:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unit_cnt <= '0;
      acc      <= '0;
    end else if (!en) begin
      unit_cnt <= '0;
      acc      <= '0;
    end else if (fall) begin
      if (last_unit) begin
        unit_cnt <= '0;
        acc      <= '0;
      end else begin
        unit_cnt <= unit_cnt + UCNT_W'(1);
        acc      <= acc_next;
      end
    end
  end

  assign push_o = fall & last_unit;
  assign word_o = acc_next;
  assign busy_o = (unit_cnt != '0);

  AST_UNIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    unit_cnt < units_per_word(word48, path8)); // R2
  AST_SHORT_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (push_o && !word48) |-> (word_o[WORD_W-1:SHORT_W] == '0)); // R2
  AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (unit_cnt == '0)); // R9
endmodule

// File: rtl/lnk_rx_fifo.sv
module lnk_rx_fifo #(
  parameter int unsigned W     = 48,
  parameter int unsigned DEPTH = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         flush,
  input  logic                         push,
  input  logic [W-1:0]                 wdata,
  input  logic                         pop,
  output logic [W-1:0]                 rdata,
  output logic [$clog2(DEPTH+1)-1:0]   count
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH+1);

  logic [W-1:0]     mem [DEPTH];
  logic [W-1:0]     last_q;
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic             do_push, do_pop;

  assign do_pop  = pop & (count != '0);
  assign do_push = push & ((count != CNT_W'(DEPTH)) | do_pop);

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH-1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= bump(wr_ptr);
      if (do_pop)  rd_ptr <= bump(rd_ptr);
      if (do_push && !do_pop)      count <= count + CNT_W'(1);
      else if (do_pop && !do_push) count <= count - CNT_W'(1);
    end
  end

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mem[i] <= '0;
        else if (do_push && !flush && wr_ptr == PTR_W'(i)) mem[i] <= wdata;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= '0;
    else if (do_pop && !flush) last_q <= mem[rd_ptr];
  end

  assign rdata = (count != '0) ? mem[rd_ptr] : last_q;

  AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH)); // R3
  AST_EMPTY_READ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0 && pop && !push && !flush) |=> (count == '0 && $stable(rdata))); // R10
endmodule

// File: rtl/lnk_pack_rx.sv
module lnk_pack_rx
  import lnk_rx_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH  = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              word48,
  input  logic              path8,
  input  logic              lnk_clk,
  input  logic [LANE_W-1:0] lnk_dat,
  output logic              lnk_ack,
  input  logic              rd_ready,
  output logic              rd_valid,
  output logic [WORD_W-1:0] rd_data,
  output logic [1:0]        status,
  output logic              pack_err
);
  localparam int unsigned CNT_W = $clog2(FIFO_DEPTH+1);

  logic [LANE_W:0]   sync_q;
  logic              push;
  logic [WORD_W-1:0] word;
  logic              busy;
  logic [CNT_W-1:0]  count;
  logic [CNT_W:0]    occupied;

  lnk_sync #(.W(LANE_W+1), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({lnk_clk, lnk_dat}), .q(sync_q));

  lnk_packer u_pack (
    .clk(clk), .rst_n(rst_n), .en(en), .word48(word48), .path8(path8),
    .strobe_s(sync_q[LANE_W]), .dat_s(sync_q[LANE_W-1:0]),
    .push_o(push), .word_o(word), .busy_o(busy));

  lnk_rx_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush(!en), .push(push), .wdata(word),
    .pop(rd_ready), .rdata(rd_data), .count(count));

  assign occupied = {1'b0, count} + {{CNT_W{1'b0}}, busy};
  assign lnk_ack  = en & (occupied < (CNT_W+1)'(FIFO_DEPTH));
  assign rd_valid = (count != '0);
  assign pack_err = busy;

  always_comb begin
    if (count == '0)                     status = ST_EMPTY;
    else if (count == CNT_W'(FIFO_DEPTH)) status = ST_FULL;
    else                                 status = ST_ONE;
  end

  AST_ACK_LOW_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (status == ST_FULL) |-> !lnk_ack); // R4
  AST_STATUS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    status != 2'b01); // R7
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (status == ST_EMPTY && !pack_err)); // R9
  AST_NO_ACK_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !lnk_ack); // R9
endmodule

// File: tb/lnk_pack_rx_tb_top.sv
module lnk_pack_rx_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0, word48 = 1'b0, path8 = 1'b0;
  logic        lnk_clk = 1'b0;
  logic [7:0]  lnk_dat = '0;
  logic        lnk_ack, rd_ready = 1'b0, rd_valid, pack_err;
  logic [47:0] rd_data;
  logic [1:0]  status;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  lnk_pack_rx dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .word48(word48), .path8(path8),
    .lnk_clk(lnk_clk), .lnk_dat(lnk_dat), .lnk_ack(lnk_ack),
    .rd_ready(rd_ready), .rd_valid(rd_valid), .rd_data(rd_data),
    .status(status), .pack_err(pack_err));

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int units_for(input logic w48, input logic p8);
    return (w48 ? 48 : 32) / (p8 ? 8 : 4);
  endfunction

  function automatic logic [47:0] rand_word(input logic w48);
    logic [47:0] w;
    w = {$urandom, $urandom};
    return w48 ? w : {16'h0, w[31:0]};
  endfunction

  function automatic logic [7:0] unit_of(input logic [47:0] w, input int idx, input logic w48, input logic p8);
    int n, ub;
    n = units_for(w48, p8);
    ub = p8 ? 8 : 4;
    return 8'((w >> ((n-1-idx)*ub)) & (p8 ? 48'hFF : 48'hF));
  endfunction

  task automatic send_unit(input logic [7:0] v, input logic [7:0] junk);
    @(negedge clk);
    lnk_dat = p8_mask(v, junk);
    lnk_clk = 1'b1;
    repeat (4) @(negedge clk);
    lnk_clk = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  function automatic logic [7:0] p8_mask(input logic [7:0] v, input logic [7:0] junk);
    return path8 ? v : {junk[7:4], v[3:0]};
  endfunction

  task automatic send_word(input logic [47:0] w);
    for (int i = 0; i < units_for(word48, path8); i++) send_unit(unit_of(w, i, word48, path8), 8'($urandom));
  endtask

  task automatic read_one();
    @(negedge clk); rd_ready = 1'b1;
    @(negedge clk); rd_ready = 1'b0;
  endtask

  task automatic set_mode(input logic w48, input logic p8);
    @(negedge clk); en = 1'b0;
    @(negedge clk); word48 = w48; path8 = p8;
    @(negedge clk); en = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [47:0] a, b;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(status == 2'b00 && !pack_err && !rd_valid && !lnk_ack, "R9 reset", {status, pack_err, rd_valid, lnk_ack}, 0);

    // Random words in all four modes
    for (int it = 0; it < 16; it++) begin
      logic w48, p8;
      int nw;
      logic [47:0] q [2];
      w48 = 1'($urandom); p8 = 1'($urandom);
      set_mode(w48, p8);
      nw = 1 + int'($urandom % 2);
      for (int k = 0; k < nw; k++) begin
        q[k] = rand_word(w48);
        send_word(q[k]);
      end
      check(status == (nw == 2 ? 2'b11 : 2'b10), "R7 fill status", status, nw == 2 ? 2'b11 : 2'b10);
      check(!pack_err, "R8 whole words", pack_err, 0);
      for (int k = 0; k < nw; k++) begin
        check(rd_valid && rd_data == q[k], "R2 R3 packed word order", rd_data, q[k]);
        read_one();
      end
      check(!rd_valid && status == 2'b00, "R3 drained", status, 0);
    end

    // Directed: ack withdrawal, trailing units, re-assert
    set_mode(1'b1, 1'b1);
    a = 48'hA1B2C3D4E5F6; b = 48'h0123456789AB;
    send_word(a);
    check(lnk_ack && status == 2'b10, "R4 ack with one word", {lnk_ack, status}, 3'b110);
    send_unit(unit_of(b, 0, 1'b1, 1'b1), 8'h0);
    check(!lnk_ack, "R4 ack withdrawn on partial", lnk_ack, 0);
    check(pack_err, "R8 partial word flagged", pack_err, 1);
    for (int i = 1; i < 6; i++) send_unit(unit_of(b, i, 1'b1, 1'b1), 8'h0);
    check(status == 2'b11 && !pack_err, "R6 trailing units stored", {status, pack_err}, 3'b110);
    check(!lnk_ack, "R4 ack low when full", lnk_ack, 0);
    check(rd_data == a, "R3 oldest first", rd_data, a);
    @(negedge clk); rd_ready = 1'b1;
    @(negedge clk); rd_ready = 1'b0;
    check(lnk_ack && status == 2'b10, "R5 ack after read", {lnk_ack, status}, 3'b110);
    check(rd_data == b, "R3 second word", rd_data, b);
    read_one();
    check(status == 2'b00, "R7 empty", status, 0);
    @(negedge clk); rd_ready = 1'b1;
    @(negedge clk); rd_ready = 1'b0;
    check(rd_data == b && status == 2'b00 && !rd_valid, "R10 empty read", rd_data, b);

    // Rising edge alone captures nothing
    set_mode(1'b0, 1'b0);
    @(negedge clk); lnk_dat = 8'h5; lnk_clk = 1'b1;
    repeat (6) @(negedge clk);
    check(!pack_err, "R1 no capture on rise", pack_err, 0);
    lnk_clk = 1'b0;
    repeat (5) @(negedge clk);
    check(pack_err, "R1 capture on fall", pack_err, 1);

    // Nibble mode ignores upper lines
    set_mode(1'b0, 1'b0);
    a = 48'h0000_9C3E_71A5;
    for (int i = 0; i < 8; i++) send_unit(unit_of(a, i, 1'b0, 1'b0), 8'hF0);
    check(rd_data == a, "R2 nibble path upper lines ignored", rd_data, a);
    read_one();

    // Disable clears partial state and ignores edges
    send_unit(8'h3, 8'h0); send_unit(8'h4, 8'h0);
    send_word(48'h1234_5678);
    check(status == 2'b10 && pack_err, "R8 partial before disable", {status, pack_err}, 3'b101);
    @(negedge clk); en = 1'b0;
    @(negedge clk);
    check(status == 2'b00 && !pack_err && !lnk_ack, "R9 disable clears", {status, pack_err, lnk_ack}, 0);
    send_unit(8'h7, 8'h0);
    @(negedge clk); en = 1'b1;
    @(negedge clk);
    check(!pack_err && status == 2'b00, "R9 edges ignored while disabled", {status, pack_err}, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule